// File: doc/BRIEF.md
# Rotated-Immediate Constant Encoder

This block decides whether a 32-bit constant can be produced by one data-processing instruction whose operand is an 8-bit field rotated right by an even number of bit positions. A start strobe captures the constant. The block then steps through candidate rotations, one per clock. It first tests the constant as given. If no rotation fits, it tests the bitwise complement of the constant, which corresponds to the move-not form of the instruction.

When the block finds a hit, or runs out of candidates, it raises a one-cycle done pulse. Alongside done it drives:
- valid, which shows whether an encoding exists;
- the form flag, use_not;
- the 8-bit immediate;
- the 4-bit rotate field, which holds half the rotate amount.

An assembler-style front end or a constant-folding unit strobes start, waits for done, and takes the encoding on that cycle.

Top module: `rotimm_encoder`

## Requirements
- R1: After reset, done and valid are low until a search completes.
- R2: When done and valid are high and use_not is 0, the captured constant equals imm8 rotated right by 2*rot4 bit positions.
- R3: When no direct encoding exists, the complement of the constant is searched. A hit there gives valid=1, use_not=1, and ~constant equal to imm8 rotated right by 2*rot4.
- R4: The complement search starts only after all 16 direct rotations have failed. A complement hit at rotate field r therefore completes 17+r cycles after the start is accepted.
- R5: Rotations are tried in ascending order of rot4 and the first fit is returned. For example, 0x3C returns rot4=0 with imm8=0x3C, not rot4=1 with imm8=0xF0.
- R6: A constant with no encoding in either form completes 32 cycles after acceptance, with valid=0 and use_not=0.
- R7: done is high for exactly one cycle per accepted start, and valid is high only while done is high.
- R8: A start that arrives while a search is in progress is ignored: it produces no result and does not change the constant being searched.
- R9: A direct hit at rotate field r completes r+1 cycles after the start is accepted. No search is busy for more than 32 cycles.
- R10: Zero encodes directly as imm8=0, rot4=0, use_not=0, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search on value; accepted only when idle |
| value | input | 32 | Constant to encode, sampled when start is accepted |
| done | output | 1 | One-cycle pulse at the end of a search |
| valid | output | 1 | Encoding found; qualified by done |
| use_not | output | 1 | 1 selects the move-not form (complement encoded) |
| imm8 | output | 8 | 8-bit immediate |
| rot4 | output | 4 | Rotate field, half the right-rotate amount |

## Verification
Every cycle, the assertions check four things:
- any reported encoding rebuilds the captured constant, or its complement when use_not is set;
- done is a single-cycle pulse, and valid never appears without it;
- a start during a search leaves the captured constant untouched;
- a search never stays busy for more than 32 cycles.

Only the bench scenarios can show the ordering effects. These are that the lowest fitting rotation wins, that the direct form is always tried before the complement, and the exact completion latency of each case. The same holds for the listed reference constants, for a constant with no encoding, and for the absence of any extra result after an ignored start.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_t;
endpackage

// File: rtl/rotimm_fit.sv
// Tests one candidate rotation: rotates the operand left by 2*rot and
// reports whether everything above the immediate field is zero.
module rotimm_fit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [ROT_W-1:0]  rot,
  output logic              hit,
  output logic [IMM_W-1:0]  imm
);
  localparam int SH_W = ROT_W + 2;
  localparam logic [SH_W-1:0] FULL = SH_W'(DATA_W);

  logic [SH_W-1:0]   shamt;
  logic [SH_W-1:0]   back;
  logic [DATA_W-1:0] rolled;

  always_comb begin
    shamt  = {1'b0, rot, 1'b0};
    back   = FULL - shamt;
    rolled = (operand << shamt) | (operand >> back);
    hit    = ~|rolled[DATA_W-1:IMM_W];
    imm    = rolled[IMM_W-1:0];
  end
endmodule

// File: rtl/rotimm_seq.sv
// Search sequencer: accepts a start while idle and walks the step counter.
// The counter MSB selects the complement phase.
module rotimm_seq #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  output logic              busy,
  output logic              accept,
  output logic              finish,
  output logic [STEP_W-1:0] step
);
  import rotimm_pkg::*;

  scan_state_t       state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    step_en = 1'b0;
    accept  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = SCAN_RUN;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      SCAN_RUN: begin
        if (hit || (&step_q)) begin
          finish  = 1'b1;
          state_d = SCAN_IDLE;
        end else begin
          step_d  = step_q + 1'b1;
          step_en = 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign busy = (state_q == SCAN_RUN);
  assign step = step_q;
endmodule

// File: rtl/rotimm_encoder.sv
module rotimm_encoder #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  localparam int ROT_W = $clog2(DATA_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] value,
  output logic              done,
  output logic              valid,
  output logic              use_not,
  output logic [IMM_W-1:0]  imm8,
  output logic [ROT_W-1:0]  rot4
);
  localparam int STEP_W = ROT_W + 1;

  logic              busy;
  logic              accept;
  logic              finish;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] operand_q;
  logic [DATA_W-1:0] cand;
  logic              hit;
  logic [IMM_W-1:0]  fit_imm;
  logic              compl_phase;

  logic              done_d, valid_d, not_d;
  logic [IMM_W-1:0]  imm_d;
  logic [ROT_W-1:0]  rot_d;
  logic              res_en;

  assign compl_phase = step[STEP_W-1];
  assign cand        = compl_phase ? ~operand_q : operand_q;

  rotimm_seq #(.STEP_W(STEP_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .hit    (hit),
    .busy   (busy),
    .accept (accept),
    .finish (finish),
    .step   (step)
  );

  rotimm_fit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_fit (
    .operand (cand),
    .rot     (step[ROT_W-1:0]),
    .hit     (hit),
    .imm     (fit_imm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) operand_q <= '0;
    else if (accept) operand_q <= value;
  end

  always_comb begin
    done_d  = finish;
    valid_d = finish & hit;
    res_en  = finish;
    not_d   = hit & compl_phase;
    imm_d   = hit ? fit_imm : '0;
    rot_d   = hit ? step[ROT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      valid   <= 1'b0;
      use_not <= 1'b0;
      imm8    <= '0;
      rot4    <= '0;
    end else begin
      done  <= done_d;
      valid <= valid_d;
      if (res_en) begin
        use_not <= not_d;
        imm8    <= imm_d;
        rot4    <= rot_d;
      end
    end
  end
endmodule

// File: rtl/rotimm_checker.sv
module rotimm_checker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [DATA_W-1:0] operand_q,
  input logic              done,
  input logic              valid,
  input logic              use_not,
  input logic [IMM_W-1:0]  imm8,
  input logic [ROT_W-1:0]  rot4
);
  localparam int CNT_W = ROT_W + 3;

  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   rebuilt;
  logic [DATA_W-1:0]   target;
  logic [CNT_W-1:0]    busy_cnt;

  always_comb begin
    wide    = {{(DATA_W-IMM_W){1'b0}}, imm8, {(DATA_W-IMM_W){1'b0}}, imm8} >> {rot4, 1'b0};
    rebuilt = wide[DATA_W-1:0];
    target  = use_not ? ~operand_q : operand_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  AST_RESULT_REBUILDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid) |-> (rebuilt == target)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(operand_q)); // R8
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(DATA_W)); // R9
endmodule

bind rotimm_encoder rotimm_checker #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .operand_q (operand_q),
  .done      (done),
  .valid     (valid),
  .use_not   (use_not),
  .imm8      (imm8),
  .rot4      (rot4)
);

// File: tb/rotimm_encoder_bench.sv
module rotimm_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] value = '0;
  logic        done, valid, use_not;
  logic [7:0]  imm8;
  logic [3:0]  rot4;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int done_seen = 0;
  int pushed = 0;

  typedef struct {
    logic [31:0] val;
    bit          ok;
    bit          inv;
    logic [7:0]  imm;
    logic [3:0]  rot;
    int          due;
    string       req;
  } exp_t;

  exp_t sbq[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  rotimm_encoder u_rotimm_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value),
    .done(done), .valid(valid), .use_not(use_not), .imm8(imm8), .rot4(rot4)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected item whenever done is seen.
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (sbq.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(valid == e.ok, e.req, "valid", valid, e.ok);
        check(cyc == e.due, e.req, "latency", cyc, e.due);
        if (e.ok) begin
          check(use_not == e.inv, e.req, "use_not", use_not, e.inv);
          check(imm8 == e.imm, e.req, "imm8", imm8, e.imm);
          check(rot4 == e.rot, e.req, "rot4", rot4, e.rot);
        end else begin
          check(use_not == 1'b0, e.req, "use_not on miss", use_not, 0);
        end
      end
    end
  end

  task automatic push(input logic [31:0] v, input bit ok, input bit inv,
                      input logic [7:0] imm, input logic [3:0] rot,
                      input int lat, input string req);
    exp_t e;
    e.val = v; e.ok = ok; e.inv = inv; e.imm = imm; e.rot = rot;
    e.due = cyc + 1 + lat; e.req = req;
    sbq.push_back(e);
    pushed++;
  endtask

  task automatic drive(input logic [31:0] v, input bit ok, input bit inv,
                       input logic [7:0] imm, input logic [3:0] rot,
                       input int lat, input string req);
    @(negedge clk);
    push(v, ok, inv, imm, rot, lat, req);
    start = 1'b1;
    value = v;
    @(negedge clk);
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(valid == 1'b0, "R1", "valid in reset", valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && valid == 1'b0, "R1", "idle outputs", {done, valid}, 0);

    drive(32'h0000_0000, 1, 0, 8'h00, 4'd0, 1, "R10");
    drive(32'h0000_00AB, 1, 0, 8'hAB, 4'd0, 1, "R2");
    drive(32'hFF00_0000, 1, 0, 8'hFF, 4'd4, 5, "R2");
    drive(32'hFC00_0003, 1, 0, 8'hFF, 4'd3, 4, "R9");
    drive(32'h8000_0001, 1, 0, 8'h06, 4'd1, 2, "R9");
    drive(32'h0000_0104, 1, 0, 8'h41, 4'd15, 16, "R5");
    drive(32'h0000_003C, 1, 0, 8'h3C, 4'd0, 1, "R5");
    drive(32'hFFFF_FFFF, 1, 1, 8'h00, 4'd0, 17, "R4");
    drive(32'h03FF_FFFC, 1, 1, 8'hFF, 4'd3, 20, "R3");
    drive(32'h5555_5555, 0, 0, 8'h00, 4'd0, 32, "R6");

    // R8: second start during a search must be ignored.
    @(negedge clk);
    push(32'h5555_5555, 0, 0, 8'h00, 4'd0, 32, "R8");
    start = 1'b1; value = 32'h5555_5555;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; value = 32'h0000_0000;
    @(negedge clk);
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(done_seen == pushed, "R8", "result count", done_seen, pushed);

    // Back-to-back accepted searches still give single pulses (R7).
    drive(32'h0000_0001, 1, 0, 8'h01, 4'd0, 1, "R7");
    check(done == 1'b0, "R7", "done after pulse", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule